// File: doc/BRIEF.md
# System Configuration Register Bank

This block holds the word-wide configuration registers of a microcontroller's system-control area and presents them on a simple word bus. The bus has a read strobe, a write strobe, a byte address, an access-size code and write data. The block returns registered read data and a one-cycle error flag. Each register applies its own write policy:
- a plain write through a fixed mask of writable bits;
- a bit that software may only clear;
- lock bits that software may only set;
- a write-one-to-clear status flag that hardware raises;
- a slot whose writes are discarded.

The four external-interrupt source selectors are driven out in parallel to a separate routing block. The remap, firewall, erase and write-protect actions that these bits would request are handled elsewhere. This block only keeps their state.

Top module: `sysctl_regbank`

## Requirements
- R1: A synchronous active-high reset loads every register in one cycle. Every register becomes 0 except config-1 (word offset 0x04), which becomes 0x7C000001. Read data and the error flag become 0, and `sel_map` becomes all zero.
- R2: A word write to the remap register (0x00) keeps only the bits in 0x00000107. A word write to a selector register (0x08, 0x0C, 0x10, 0x14) keeps only bits [15:0]. The four selector values appear on `sel_map`, with selector k (offset 0x08+4k) on bits [16k+15:16k]. `sel_map` changes only after a write.
- R3: A write to config-1 (0x04) stores `wdata & 0xFCFF0100` in the other bits. Bit 0 becomes old bit 0 AND written bit 0, so after reset bit 0 can be cleared but not set again.
- R4: In config-2 (0x1C), bits [3:0] are lock bits: a write ORs the written bits in, and only reset clears them. Bit 8 is a status flag: `par_err_evt` sets it, writing 1 clears it, and writing 0 leaves it. When the event and a clearing write fall in the same cycle, the flag ends set.
- R5: Protect-1 (0x20) and protect-2 (0x28) OR each written value into their content. Only reset clears them.
- R6: The key register (0x24) keeps only bits [7:0]. The SRAM control slot (0x18) is a valid address, but writes to it are discarded and it always reads 0.
- R7: Word offsets 0x2C to 0x3FC are unmapped. A read there returns 0, and a write there changes no register. Either access raises `bus_err` in the cycle after the strobe, for one cycle per bad access.
- R8: An access with `bus_size` other than 2'b10 (word) or with `bus_addr[1:0]` not 0 counts as bad. It raises `bus_err` like R7, returns 0 on a read and changes no register. The size codes are 2'b00 byte, 2'b01 half and 2'b11 reserved.
- R9: Read data appears on `bus_rdata` in the cycle after `bus_rd` and holds until the next read. When `bus_rd` and `bus_wr` are both high, the read returns the value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | ADDR_W | Byte address inside the 0x400-byte window |
| bus_size | input | 2 | Access size code, 2'b10 = word |
| bus_wdata | input | 32 | Write data |
| par_err_evt | input | 1 | Hardware event that sets the config-2 status flag |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle pulse after a bad access |
| sel_map | output | 64 | The four interrupt selector fields, packed |

## Verification
The hardest case to reach is a config-2 status flag that the hardware event sets in the same cycle as a write that clears it. The bench drives `par_err_evt` together with a write of 0x100, so both arrive on one edge. Reaching config-1 bit 0 set again after it was cleared needs a reset partway through the run. The bench issues that reset after the lock bits and protect bits are loaded, so the same reset also shows that they clear. Bad accesses are sent between good ones, and every register is then read back. This shows that nothing moved.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int DW      = 32;
    localparam int NREG    = 11;
    localparam int SEL_CNT = 4;
    localparam int SEL_W   = 16;

    // word index of each register; the decode depends on this order
    localparam int IX_REMAP  = 0;
    localparam int IX_CFG1   = 1;
    localparam int IX_SEL0   = 2;
    localparam int IX_SRAMCS = 6;
    localparam int IX_CFG2   = 7;
    localparam int IX_WP1    = 8;
    localparam int IX_KEY    = 9;
    localparam int IX_WP2    = 10;

    localparam logic [1:0]    SZ_WORD    = 2'b10;
    localparam logic [DW-1:0] M_REMAP    = 32'h0000_0107;
    localparam logic [DW-1:0] M_CFG1_HI  = 32'hFCFF_0100;
    localparam logic [DW-1:0] M_CFG1_EN  = 32'h0000_0001;
    localparam logic [DW-1:0] M_SEL      = 32'h0000_FFFF;
    localparam logic [DW-1:0] M_LOCK     = 32'h0000_000F;
    localparam logic [DW-1:0] M_PEF      = 32'h0000_0100;
    localparam logic [DW-1:0] M_KEY      = 32'h0000_00FF;
    localparam logic [DW-1:0] RST_CFG1   = 32'h7C00_0001;

    typedef logic [NREG-1:0][DW-1:0] bank_t;

    function automatic bank_t bank_reset();
        bank_t r;
        for (int i = 0; i < NREG; i++) begin
            r[i] = (i == IX_CFG1) ? RST_CFG1 : '0;
        end
        return r;
    endfunction

    // value a register takes after a software write of wd
    function automatic logic [DW-1:0] wr_policy(input int idx,
                                                input logic [DW-1:0] cur,
                                                input logic [DW-1:0] wd);
        logic [DW-1:0] v;
        if (idx == IX_REMAP) begin
            v = wd & M_REMAP;
        end else if (idx == IX_CFG1) begin
            v = (wd & M_CFG1_HI) | (cur & wd & M_CFG1_EN);
        end else if (idx >= IX_SEL0 && idx < IX_SEL0 + SEL_CNT) begin
            v = wd & M_SEL;
        end else if (idx == IX_CFG2) begin
            v = (cur | (wd & M_LOCK)) & ~(wd & M_PEF);
        end else if (idx == IX_WP1 || idx == IX_WP2) begin
            v = cur | wd;
        end else if (idx == IX_KEY) begin
            v = wd & M_KEY;
        end else begin
            v = '0;
        end
        return v;
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    output logic [NREG-1:0]   rd_hit,
    output logic [NREG-1:0]   wr_hit,
    output logic              bad
);

    localparam int WA_W = ADDR_W - 2;

    logic [WA_W-1:0] word_addr;
    logic            fmt_ok;
    logic            mapped;

    assign word_addr = bus_addr[ADDR_W-1:2];
    assign fmt_ok    = (bus_size == SZ_WORD) && (bus_addr[1:0] == 2'b00);
    assign mapped    = word_addr < WA_W'(NREG);
    assign bad       = (bus_rd | bus_wr) & ~(fmt_ok & mapped);

    for (genvar g = 0; g < NREG; g++) begin : g_hit
        logic sel;
        assign sel       = fmt_ok && (word_addr == WA_W'(g));
        assign rd_hit[g] = bus_rd & sel;
        assign wr_hit[g] = bus_wr & sel;
    end

endmodule

// File: rtl/sysctl_update.sv
module sysctl_update
    import sysctl_pkg::*;
(
    input  bank_t             cur,
    input  logic [NREG-1:0]   wr_hit,
    input  logic [DW-1:0]     wdata,
    input  logic              par_evt,
    output bank_t             nxt
);

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DW-1:0] wval;
        assign wval = wr_hit[g] ? wr_policy(g, cur[g], wdata) : cur[g];
        if (g == IX_CFG2) begin : g_flag
            // hardware event wins over a clearing write in the same cycle
            assign nxt[g] = wval | (par_evt ? M_PEF : '0);
        end else begin : g_plain
            assign nxt[g] = wval;
        end
    end

endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
    import sysctl_pkg::*;
(
    input  bank_t           cur,
    input  logic [NREG-1:0] rd_hit,
    output logic [DW-1:0]   rval
);

    always_comb begin
        rval = '0;
        for (int i = 0; i < NREG; i++) begin
            rval = rval | ({DW{rd_hit[i]}} & cur[i]);
        end
    end

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
    import sysctl_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_rd,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [1:0]               bus_size,
    input  logic [DW-1:0]            bus_wdata,
    input  logic                     par_err_evt,
    output logic [DW-1:0]            bus_rdata,
    output logic                     bus_err,
    output logic [SEL_CNT*SEL_W-1:0] sel_map
);

    typedef struct packed {
        bank_t         bank;
        logic [DW-1:0] rdata;
        logic          err;
    } state_t;

    state_t          st_d;
    state_t          st_q;
    bank_t           bank_q;
    bank_t           bank_nxt;
    logic [NREG-1:0] rd_hit;
    logic [NREG-1:0] wr_hit;
    logic            acc_bad;
    logic [DW-1:0]   rd_val;

    assign bank_q = st_q.bank;

    sysctl_decode #(.ADDR_W(ADDR_W)) u_decode (
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_size (bus_size),
        .rd_hit   (rd_hit),
        .wr_hit   (wr_hit),
        .bad      (acc_bad)
    );

    sysctl_update u_update (
        .cur     (bank_q),
        .wr_hit  (wr_hit),
        .wdata   (bus_wdata),
        .par_evt (par_err_evt),
        .nxt     (bank_nxt)
    );

    sysctl_rdmux u_rdmux (
        .cur    (bank_q),
        .rd_hit (rd_hit),
        .rval   (rd_val)
    );

    always_comb begin
        st_d       = st_q;
        st_d.bank  = bank_nxt;
        st_d.rdata = bus_rd ? rd_val : st_q.rdata;
        st_d.err   = acc_bad;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.bank  <= bank_reset();
            st_q.rdata <= '0;
            st_q.err   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign bus_err   = st_q.err;

    for (genvar k = 0; k < SEL_CNT; k++) begin : g_sel
        assign sel_map[k*SEL_W +: SEL_W] = bank_q[IX_SEL0 + k][SEL_W-1:0];
    end

endmodule

// File: rtl/sysctl_regbank_chk.sv
module sysctl_regbank_chk
    import sysctl_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     bus_rd,
    input logic                     bus_wr,
    input logic                     bus_err,
    input logic [SEL_CNT*SEL_W-1:0] sel_map,
    input bank_t                    bank
);

    bank_t bank_m;

    always_comb begin
        bank_m          = bank;
        bank_m[IX_CFG2] = bank[IX_CFG2] & ~M_PEF;
    end

    AST_RST_CFG1: assert property (@(posedge clk)
        $past(rst) |-> (bank[IX_CFG1] == RST_CFG1 && bank[IX_CFG2] == '0)); // R1

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(bus_wr)) |-> $stable(sel_map)); // R2

    AST_CFG1_EN_NO_SET: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> !$rose(bank[IX_CFG1][0])); // R3

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((bank[IX_CFG2][3:0] & $past(bank[IX_CFG2][3:0])) == $past(bank[IX_CFG2][3:0]))); // R4

    AST_WP1_STICKY: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((bank[IX_WP1] & $past(bank[IX_WP1])) == $past(bank[IX_WP1]))); // R5

    AST_WP2_STICKY: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((bank[IX_WP2] & $past(bank[IX_WP2])) == $past(bank[IX_WP2]))); // R5

    AST_ERR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> $past(bus_rd || bus_wr)); // R7

    AST_BAD_WRITE_INERT: assert property (@(posedge clk) disable iff (rst)
        (bus_err && $past(bus_wr) && !$past(rst)) |-> (bank_m == $past(bank_m))); // R8

endmodule

bind sysctl_regbank sysctl_regbank_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .bus_rd  (bus_rd),
    .bus_wr  (bus_wr),
    .bus_err (bus_err),
    .sel_map (sel_map),
    .bank    (bank_q)
);

// File: tb/sysctl_regbank_bench.sv
`timescale 1ns/1ps
module sysctl_regbank_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [1:0]  bus_size = 2'b10;
    logic [31:0] bus_wdata = '0;
    logic        par_err_evt = 1'b0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [63:0] sel_map;

    int checks = 0;
    int errors = 0;

    // behavioural model: one word per offset/4, plus last read and error
    logic [31:0] mreg [11];
    logic [31:0] m_rdata;
    logic        m_err;

    always #2 clk = ~clk;

    sysctl_regbank u_sysctl_regbank (
        .clk         (clk),
        .rst         (rst),
        .bus_rd      (bus_rd),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_size    (bus_size),
        .bus_wdata   (bus_wdata),
        .par_err_evt (par_err_evt),
        .bus_rdata   (bus_rdata),
        .bus_err     (bus_err),
        .sel_map     (sel_map)
    );

    task automatic compare(input string tag, input string what,
                           input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] m_sel();
        return {mreg[5][15:0], mreg[4][15:0], mreg[3][15:0], mreg[2][15:0]};
    endfunction

    task automatic m_reset();
        foreach (mreg[i]) mreg[i] = 32'h0;
        mreg[1] = 32'h7C00_0001;
        m_rdata = '0;
        m_err   = 1'b0;
    endtask

    task automatic m_write(input int idx, input logic [31:0] v);
        case (idx)
            0:          mreg[0] = v & 32'h107;
            1:          mreg[1] = (v & 32'hFCFF_0100) | {31'h0, mreg[1][0] & v[0]};
            2, 3, 4, 5: mreg[idx] = {16'h0, v[15:0]};
            6:          mreg[6] = 32'h0;
            7: begin
                mreg[7][3:0] = mreg[7][3:0] | v[3:0];
                if (v[8]) mreg[7][8] = 1'b0;
            end
            8, 10:      mreg[idx] = mreg[idx] | v;
            9:          mreg[9] = {24'h0, v[7:0]};
            default: ;
        endcase
    endtask

    task automatic acc(input logic rd, input logic wr, input logic [9:0] a,
                       input logic [31:0] wd, input logic [1:0] sz,
                       input logic par, input string tag);
        logic bad;
        bad = (sz != 2'b10) || (a[1:0] != 2'b00) || (a[9:2] > 8'd10);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        bus_size = sz; par_err_evt = par;
        if (rd) m_rdata = bad ? 32'h0 : mreg[int'(a[9:2])];
        m_err = (rd || wr) && bad;
        if (wr && !bad) m_write(int'(a[9:2]), wd);
        if (par) mreg[7][8] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; par_err_evt = 1'b0; bus_size = 2'b10;
        compare(tag, "rdata", {32'h0, bus_rdata}, {32'h0, m_rdata});
        compare(tag, "err", {63'h0, bus_err}, {63'h0, m_err});
        compare(tag, "sel_map", sel_map, m_sel());
    endtask

    task automatic rd(input logic [9:0] a, input string tag);
        acc(1'b1, 1'b0, a, 32'h0, 2'b10, 1'b0, tag);
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d, input string tag);
        acc(1'b0, 1'b1, a, d, 2'b10, 1'b0, tag);
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < 11; i++) rd(10'(i * 4), tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_reset();
        compare("R1", "rdata", {32'h0, bus_rdata}, 64'h0);
        compare("R1", "err", {63'h0, bus_err}, 64'h0);
        compare("R1", "sel_map", sel_map, 64'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual running expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        m_reset();
        repeat (2) @(posedge clk);
        do_reset();
        read_all("R1");

        // R2 masked remap and selectors
        wr(10'h000, 32'hFFFF_FFFF, "R2");
        rd(10'h000, "R2");
        wr(10'h008, 32'hDEAD_1234, "R2");
        wr(10'h00C, 32'hBEEF_5678, "R2");
        wr(10'h010, 32'h0000_9ABC, "R2");
        wr(10'h014, 32'hFFFF_0DEF, "R2");
        for (int i = 0; i < 4; i++) rd(10'(8 + 4 * i), "R2");
        wr(10'h010, 32'h0000_0001, "R2");

        // R3 config-1 clear-only bit 0
        wr(10'h004, 32'hFFFF_FFFF, "R3");
        rd(10'h004, "R3");
        wr(10'h004, 32'h0000_0000, "R3");
        rd(10'h004, "R3");
        wr(10'h004, 32'h0000_0001, "R3");
        rd(10'h004, "R3");

        // R4 lock bits and status flag
        wr(10'h01C, 32'h0000_0005, "R4");
        wr(10'h01C, 32'h0000_0002, "R4");
        wr(10'h01C, 32'h0000_0000, "R4");
        rd(10'h01C, "R4");
        acc(1'b0, 1'b0, 10'h000, 32'h0, 2'b10, 1'b1, "R4");
        rd(10'h01C, "R4");
        wr(10'h01C, 32'h0000_0000, "R4");
        rd(10'h01C, "R4");
        wr(10'h01C, 32'h0000_0100, "R4");
        rd(10'h01C, "R4");
        acc(1'b0, 1'b1, 10'h01C, 32'h0000_0100, 2'b10, 1'b1, "R4");
        rd(10'h01C, "R4");

        // R5 accumulating protect registers
        wr(10'h020, 32'h0000_0011, "R5");
        wr(10'h020, 32'h0000_0022, "R5");
        wr(10'h020, 32'h0000_0000, "R5");
        rd(10'h020, "R5");
        wr(10'h028, 32'h8000_0000, "R5");
        wr(10'h028, 32'h0000_0F00, "R5");
        rd(10'h028, "R5");

        // R6 key mask and discarded SRAM control writes
        wr(10'h024, 32'h1234_ABCD, "R6");
        rd(10'h024, "R6");
        wr(10'h018, 32'hFFFF_FFFF, "R6");
        rd(10'h018, "R6");

        // R7 unmapped offsets
        wr(10'h02C, 32'hFFFF_FFFF, "R7");
        rd(10'h02C, "R7");
        wr(10'h3FC, 32'hFFFF_FFFF, "R7");
        rd(10'h3FC, "R7");
        acc(1'b0, 1'b0, 10'h000, 32'h0, 2'b10, 1'b0, "R7");
        read_all("R7");

        // R8 wrong size or misaligned
        acc(1'b0, 1'b1, 10'h000, 32'h0, 2'b00, 1'b0, "R8");
        acc(1'b0, 1'b1, 10'h024, 32'h0, 2'b01, 1'b0, "R8");
        acc(1'b1, 1'b0, 10'h024, 32'h0, 2'b11, 1'b0, "R8");
        acc(1'b0, 1'b1, 10'h00A, 32'h0, 2'b10, 1'b0, "R8");
        acc(1'b1, 1'b0, 10'h005, 32'h0, 2'b10, 1'b0, "R8");
        read_all("R8");

        // R9 read and write together returns the old value
        acc(1'b1, 1'b1, 10'h024, 32'h0000_0077, 2'b10, 1'b0, "R9");
        acc(1'b0, 1'b0, 10'h000, 32'h0, 2'b10, 1'b0, "R9");
        rd(10'h024, "R9");

        // R1 reset partway through clears sticky state and restores bit 0
        wr(10'h01C, 32'h0000_000F, "R4");
        do_reset();
        read_all("R1");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule